// File: doc/BRIEF.md
# Fixed-Width Block Packer

The block packer sits at the end of a stall-free coalescing path. Every clock cycle it takes one variable-length group of words (between zero and `MAX_IN` words of `WORD_W` bits each) and appends it to a holding buffer. As soon as the buffer holds enough words to fill one output block of `BLOCK_W` bits (512 by default), the block is written towards a downstream FIFO. Any words that did not fit are moved to the front of the buffer in the same cycle, so nothing is lost and the input is never held off.

Each block begins with a marker word that gives the payload index of the first word of the earliest group that starts inside that block. After a transmission error, a receiver can use it to find where the next whole group begins. The buffer is the only storage on the path. It is sized so that a worst-case group always fits alongside a nearly full buffer. When the FIFO reports full while a block is offered, the block is discarded and a sticky flag is raised. The input keeps flowing.

Top module: `blk_packer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties the buffer and clears the overflow flag. After reset, `blk_wr` and `ovf_flag` are 0, and the first group that follows starts at payload index 0.
- R2: Payload words leave in arrival order. Word k of `in_data` is bits [16k+15:16k]. Block word 0 (bits [15:0]) is the marker, and block words 1 to 31 carry payload indices 0 to 30.
- R3: Words of `in_data` at positions at or beyond `in_len` have no effect on any block.
- R4: When the words held plus `in_len` reach 31 or more at a clock edge, the block is presented from that edge until the next one. `blk_wr` is high during that cycle unless `fifo_full` is high.
- R5: Words beyond the 31 that form a block are kept in order and become payload indices 0 onward of the following block. Nothing is lost or duplicated.
- R6: When the total is exactly 31, the buffer is left empty, so the next group starts at payload index 0.
- R7: The marker is the payload index at which the first non-empty group starting in the block begins. Words carried over from an earlier group do not count as a start. The marker is 16'hFFFF if no group starts in the block.
- R8: A cycle with `in_len` = 0 adds no words, produces no block and starts no group.
- R9: If `fifo_full` is high while a block is presented, `blk_wr` stays low, the block is dropped, and `ovf_flag` goes high at the next edge and stays high until reset. Later blocks are still correct.
- R10: A group of up to `MAX_IN` = 8 words is accepted every cycle, back to back, and all words arrive in order across blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_len | input | 4 | Number of valid words this cycle (0 to 8) |
| in_data | input | 128 | Up to 8 words; word k in bits [16k+15:16k] |
| fifo_full | input | 1 | Downstream FIFO cannot take a block |
| blk_wr | output | 1 | Write strobe for the presented block |
| blk_data | output | 512 | Marker word followed by 31 payload words |
| ovf_flag | output | 1 | Sticky flag: a block was dropped |

## Verification
Every result of this block appears one clock edge after the input cycle that causes it. The block completed by a group is on `blk_data`, with `blk_wr` qualified by `fifo_full`, for the cycle that follows the edge that captured the group. The overflow flag rises one edge after that. The bench drives each group at a falling edge and waits for the rising edge that captures it. It checks the block outputs at the next falling edge. It changes `fifo_full` only just after a rising edge, so the strobe and the flag see the same value. A model in the bench, built from the requirements, predicts the payload, the marker and the flag for every step.

// File: rtl/pk_pkg.sv
package pk_pkg;
    localparam int PK_BLOCK_W = 512;
    localparam int PK_WORD_W  = 16;
    localparam int PK_MAX_IN  = 8;

    // bits needed to hold values 0..n
    function automatic int bits_for(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/pk_append.sv
// Places the incoming group directly after the words already held.
module pk_append #(
    parameter int WORD_W = 16,
    parameter int MAX_IN = 8,
    parameter int PAY    = 31,
    parameter int TOT_W  = 6,
    parameter int LEN_W  = 4,
    localparam int CAT   = PAY + MAX_IN
) (
    input  logic [PAY-1:0][WORD_W-1:0]    held_w,
    input  logic [TOT_W-1:0]              fill,
    input  logic [MAX_IN-1:0][WORD_W-1:0] in_w,
    input  logic [LEN_W-1:0]              in_len,
    output logic [CAT-1:0][WORD_W-1:0]    cat_w
);
    for (genvar i = 0; i < CAT; i++) begin : g_slot
        logic [WORD_W-1:0] from_held;
        if (i < PAY) begin : g_held
            assign from_held = (i < int'(fill)) ? held_w[i] : '0;
        end else begin : g_none
            assign from_held = '0;
        end
        always_comb begin
            cat_w[i] = from_held;
            for (int k = 0; k < MAX_IN; k++) begin
                if (k < int'(in_len) && int'(fill) + k == i) begin
                    cat_w[i] = in_w[k];
                end
            end
        end
    end
endmodule

// File: rtl/pk_marker.sv
// Tracks where the first group of the open block starts.
module pk_marker #(
    parameter int WORD_W = 16,
    parameter int TOT_W  = 6,
    parameter int LEN_W  = 4
) (
    input  logic              lead_vld,
    input  logic [TOT_W-1:0]  lead_off,
    input  logic [TOT_W-1:0]  fill,
    input  logic [LEN_W-1:0]  in_len,
    output logic [WORD_W-1:0] mark_w,
    output logic              nxt_vld,
    output logic [TOT_W-1:0]  nxt_off
);
    always_comb begin
        nxt_vld = lead_vld || (in_len != '0);
        nxt_off = lead_vld ? lead_off : fill;
        mark_w  = nxt_vld ? WORD_W'(nxt_off) : '1;
    end
endmodule

// File: rtl/pk_realign.sv
// Splits the joined words into the outgoing payload and the next buffer.
module pk_realign #(
    parameter int WORD_W = 16,
    parameter int MAX_IN = 8,
    parameter int PAY    = 31,
    localparam int CAT   = PAY + MAX_IN
) (
    input  logic [CAT-1:0][WORD_W-1:0] cat_w,
    input  logic                       emit,
    output logic [PAY-1:0][WORD_W-1:0] head_w,
    output logic [PAY-1:0][WORD_W-1:0] next_w
);
    assign head_w = cat_w[PAY-1:0];

    for (genvar j = 0; j < PAY; j++) begin : g_next
        if (j < MAX_IN) begin : g_carry
            assign next_w[j] = emit ? cat_w[PAY+j] : cat_w[j];
        end else begin : g_plain
            assign next_w[j] = emit ? '0 : cat_w[j];
        end
    end
endmodule

// File: rtl/blk_packer.sv
module blk_packer
    import pk_pkg::*;
#(
    parameter int BLOCK_W = PK_BLOCK_W,
    parameter int WORD_W  = PK_WORD_W,
    parameter int MAX_IN  = PK_MAX_IN,
    parameter bit MARK_EN = 1'b1,
    localparam int BLK_WORDS = BLOCK_W / WORD_W,
    localparam int PAY       = BLK_WORDS - (MARK_EN ? 1 : 0),
    localparam int CAT       = PAY + MAX_IN,
    localparam int TOT_W     = bits_for(CAT),
    localparam int LEN_W     = bits_for(MAX_IN)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [LEN_W-1:0]         in_len,
    input  logic [MAX_IN*WORD_W-1:0] in_data,
    input  logic                     fifo_full,
    output logic                     blk_wr,
    output logic [BLOCK_W-1:0]       blk_data,
    output logic                     ovf_flag
);
    typedef struct packed {
        logic [PAY-1:0][WORD_W-1:0] words;
        logic [TOT_W-1:0]           fill;
        logic                       lead_vld;
        logic [TOT_W-1:0]           lead_off;
        logic [BLOCK_W-1:0]         blk;
        logic                       vld;
        logic                       ovf;
    } st_t;

    st_t st_d, st_q;

    logic [MAX_IN-1:0][WORD_W-1:0] in_w;
    logic [CAT-1:0][WORD_W-1:0]    cat_w;
    logic [PAY-1:0][WORD_W-1:0]    head_w, next_w;
    logic [WORD_W-1:0]             mark_w;
    logic                          nxt_vld;
    logic [TOT_W-1:0]              nxt_off;
    logic [TOT_W-1:0]              total;
    logic                          emit;
    logic [BLOCK_W-1:0]            blk_asm;

    assign in_w  = in_data;
    assign total = st_q.fill + TOT_W'(in_len);
    assign emit  = int'(total) >= PAY;

    pk_append #(.WORD_W(WORD_W), .MAX_IN(MAX_IN), .PAY(PAY), .TOT_W(TOT_W), .LEN_W(LEN_W))
    u_append (
        .held_w (st_q.words),
        .fill   (st_q.fill),
        .in_w   (in_w),
        .in_len (in_len),
        .cat_w  (cat_w)
    );

    pk_marker #(.WORD_W(WORD_W), .TOT_W(TOT_W), .LEN_W(LEN_W)) u_marker (
        .lead_vld (st_q.lead_vld),
        .lead_off (st_q.lead_off),
        .fill     (st_q.fill),
        .in_len   (in_len),
        .mark_w   (mark_w),
        .nxt_vld  (nxt_vld),
        .nxt_off  (nxt_off)
    );

    pk_realign #(.WORD_W(WORD_W), .MAX_IN(MAX_IN), .PAY(PAY)) u_realign (
        .cat_w  (cat_w),
        .emit   (emit),
        .head_w (head_w),
        .next_w (next_w)
    );

    if (MARK_EN) begin : g_mark
        assign blk_asm = {head_w, mark_w};
    end else begin : g_nomark
        assign blk_asm = head_w;
    end

    always_comb begin
        st_d          = st_q;
        st_d.words    = next_w;
        st_d.fill     = emit ? total - TOT_W'(PAY) : total;
        st_d.lead_vld = emit ? 1'b0 : nxt_vld;
        st_d.lead_off = emit ? '0 : nxt_off;
        st_d.vld      = emit;
        st_d.blk      = emit ? blk_asm : st_q.blk;
        st_d.ovf      = st_q.ovf || (st_q.vld && fifo_full);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign blk_wr   = st_q.vld && !fifo_full;
    assign blk_data = st_q.blk;
    assign ovf_flag = st_q.ovf;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (st_q.fill == '0 && !st_q.vld && !st_q.ovf && !st_q.lead_vld));

    // R10
    in_len_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(in_len) <= MAX_IN);

    // R6
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(st_q.fill) < PAY);

    // R5
    carry_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(st_q.fill) + int'(in_len) >= PAY) |=>
        (st_q.vld && int'(st_q.fill) == int'($past(st_q.fill)) + int'($past(in_len)) - PAY));

    // R8
    zero_len_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_len == '0) |=> (!st_q.vld && st_q.fill == $past(st_q.fill)));

    // R9
    drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.vld && fifo_full) |=> st_q.ovf);

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.ovf |=> st_q.ovf);
endmodule

// File: tb/test_blk_packer.sv
module test_blk_packer;
    localparam int PAY = 31;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   in_len = '0;
    logic [127:0] in_data = '0;
    logic         fifo_full = 1'b0;
    logic         blk_wr;
    logic [511:0] blk_data;
    logic         ovf_flag;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    logic [15:0] mbuf [0:63];
    int          mfill;
    int          mfirst;
    bit          ovf_seen;

    always #10 clk = ~clk;

    blk_packer i_blk_packer (
        .clk       (clk),
        .rst       (rst),
        .in_len    (in_len),
        .in_data   (in_data),
        .fifo_full (fifo_full),
        .blk_wr    (blk_wr),
        .blk_data  (blk_data),
        .ovf_flag  (ovf_flag)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_len = '0;
        repeat (2) @(posedge clk);
        #2 fifo_full = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        mfill = 0;
        mfirst = -1;
        ovf_seen = 1'b0;
        for (int i = 0; i < 64; i++) mbuf[i] = '0;
        check(blk_wr == 1'b0, "R1", "blk_wr after reset", 32'(blk_wr), 0);
        check(ovf_flag == 1'b0, "R1", "ovf_flag after reset", 32'(ovf_flag), 0);
    endtask

    // One input cycle; 'full' is the FIFO state while the result is shown.
    task automatic step(input int len, input logic [15:0] base, input bit full,
                        input string tag);
        logic [15:0] eblk [0:31];
        bit          exp_emit;
        bit          exp_ovf;
        int          bad;
        exp_emit = 1'b0;
        for (int k = 0; k < 8; k++)
            in_data[k*16 +: 16] = (k < len) ? base + 16'(k) : 16'hDEAD;
        in_len = 4'(len);
        if (len > 0 && mfirst < 0) mfirst = mfill;
        for (int k = 0; k < len; k++) mbuf[mfill + k] = base + 16'(k);
        mfill += len;
        if (mfill >= PAY) begin
            exp_emit = 1'b1;
            eblk[0] = (mfirst < 0) ? 16'hFFFF : 16'(mfirst);
            for (int i = 0; i < PAY; i++) eblk[i+1] = mbuf[i];
            for (int i = 0; i < 32; i++) mbuf[i] = (i + PAY < 64) ? mbuf[i+PAY] : '0;
            mfill -= PAY;
            mfirst = -1;
        end
        @(posedge clk);
        #2 fifo_full = full;
        @(negedge clk);
        in_len = '0;
        exp_ovf = ovf_seen;
        check(blk_wr == (exp_emit && !full), "R4", "blk_wr", 32'(blk_wr),
              32'(exp_emit && !full));
        check(ovf_flag == exp_ovf, "R9", "ovf_flag", 32'(ovf_flag), 32'(exp_ovf));
        if (exp_emit) begin
            check(blk_data[15:0] == eblk[0], "R7", "marker", 32'(blk_data[15:0]),
                  32'(eblk[0]));
            bad = -1;
            for (int i = 31; i >= 1; i--)
                if (blk_data[i*16 +: 16] != eblk[i]) bad = i;
            if (bad < 0)
                check(1'b1, tag, "payload", 0, 0);
            else
                check(1'b0, tag, $sformatf("payload word %0d", bad),
                      32'(blk_data[bad*16 +: 16]), 32'(eblk[bad]));
            if (full) ovf_seen = 1'b1;
        end
    endtask

    task automatic t_reset();
        do_reset();
        step(3, 16'h0100, 1'b0, "R1");
        check(blk_wr == 1'b0, "R1", "no block on fresh start", 32'(blk_wr), 0);
    endtask

    task automatic t_order_exact();
        do_reset();
        step(5, 16'h1000, 1'b0, "R2");
        step(7, 16'h1100, 1'b0, "R2");
        step(8, 16'h1200, 1'b0, "R2");
        step(6, 16'h1300, 1'b0, "R2");
        step(5, 16'h1400, 1'b0, "R6");
        check(blk_data[31:16] == 16'h1000, "R2", "first payload word",
              32'(blk_data[31:16]), 32'h1000);
        step(4, 16'h1500, 1'b0, "R6");
        step(8, 16'h1600, 1'b0, "R6");
        step(8, 16'h1700, 1'b0, "R6");
        step(8, 16'h1800, 1'b0, "R6");
        step(3, 16'h1900, 1'b0, "R6");
        check(blk_data[15:0] == 16'h0000, "R6", "marker after exact fill",
              32'(blk_data[15:0]), 0);
    endtask

    task automatic t_carry();
        do_reset();
        for (int i = 0; i < 4; i++) step(8, 16'(16'h2000 + i*16), 1'b0, "R5");
        check(blk_data[511:496] == 16'h2036, "R5", "last word of block",
              32'(blk_data[511:496]), 32'h2036);
        for (int i = 0; i < 4; i++) step(8, 16'(16'h2100 + i*16), 1'b0, "R5");
        check(blk_data[31:16] == 16'h2037, "R5", "carried word leads block",
              32'(blk_data[31:16]), 32'h2037);
        check(blk_data[15:0] == 16'h0001, "R7", "marker skips carried word",
              32'(blk_data[15:0]), 1);
    endtask

    task automatic t_ignore_zero();
        do_reset();
        step(2, 16'h3000, 1'b0, "R3");
        for (int i = 0; i < 5; i++) step(0, 16'h3F00, 1'b0, "R8");
        check(blk_wr == 1'b0, "R8", "idle cycles give no block", 32'(blk_wr), 0);
        for (int i = 0; i < 3; i++) step(7, 16'(16'h3100 + i*16), 1'b0, "R3");
        step(0, 16'h3E00, 1'b0, "R8");
        step(1, 16'h3200, 1'b0, "R3");
        step(7, 16'h3300, 1'b0, "R3");
        check(blk_wr == 1'b1, "R3", "block after 31 words", 32'(blk_wr), 1);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int i = 0; i < 3; i++) step(8, 16'(16'h4000 + i*16), 1'b0, "R9");
        step(8, 16'h4030, 1'b1, "R9");
        check(blk_wr == 1'b0, "R9", "dropped block not written", 32'(blk_wr), 0);
        for (int i = 0; i < 8; i++) step(8, 16'(16'h4100 + i*16), 1'b0, "R9");
        check(ovf_flag == 1'b1, "R9", "flag stays set", 32'(ovf_flag), 1);
        do_reset();
        check(ovf_flag == 1'b0, "R1", "reset clears flag", 32'(ovf_flag), 0);
    endtask

    task automatic t_stream();
        do_reset();
        for (int i = 0; i < 40; i++) step(8, 16'(16'h5000 + i*8), 1'b0, "R10");
        for (int i = 0; i < 60; i++) step((i * 3) % 9, 16'(16'h6000 + i*16), 1'b0, "R10");
    endtask

    initial begin
        t_reset();
        t_order_exact();
        t_carry();
        t_ignore_zero();
        t_overflow();
        t_stream();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule